// File: doc/BRIEF.md
# Gate Drive Interlock and Fault Supervisor

This block sits between the PWM outputs of a motor controller and the gate drivers of a three-phase inverter bridge plus one power-factor-correction (PFC) switch. For each phase it takes a high-side and a low-side command. It turns on only the switch that was asked for alone, and it turns both off when both are asked for. It also passes the PFC command through when operation is allowed.

Two digitized over-current flags are filtered before they act. The inverter flag and the PFC flag each have their own filter. A flag must stay high for a blanking window before it is accepted. An accepted trip then waits for a propagation delay, after which it latches a fault. The fault shuts every switch. It clears only after both flags have stayed low for a clearance time. A main-supply undervoltage flag also forces the fault and shuts every switch, for as long as it lasts. It also disarms the high sides. A disarmed high side is re-armed only when its own phase sees a low-side command. A per-phase bootstrap undervoltage flag removes only that phase's high side. An enable input gates all switches without touching the fault.

All intervals are counted in clock cycles and set by parameters. Every output is a register. Reset is asynchronous and active low, and it is released through a two-stage synchronizer. Inputs pass through one register stage, so a command reaches its gate output on the second rising edge after it changes.

Top module: `gate_guard`

## Requirements
- R1: When the high and low commands of a phase are both 1, both gate outputs of that phase are 0 from the second clock edge on. Other phases are not affected.
- R2: With no fault and the enable at 1, a phase whose low command alone is 1 drives its low gate to 1. A phase whose high command alone is 1 drives its high gate to 1, provided that phase is armed and its bootstrap flag is 1. The latency is two clock edges. With neither command at 1, both gates are 0.
- R3: An over-current flag that is 1 on fewer than BLANK_CYC consecutive clock edges has no effect on the fault output or on the gates.
- R4: An over-current flag that is 1 on BLANK_CYC consecutive edges sets the fault output PROP_CYC+1 edges after the last of those edges. This holds for the inverter flag and for the PFC flag alike. One edge after the fault rises, every gate output is 0, the PFC gate included, whatever the commands are.
- R5: A fault set by a trip stays at 1 while either flag is 1. It falls CLEAR_CYC edges after the first edge that samples both flags at 0. A flag returning to 1 during that wait restarts the wait. The gates follow their commands again one edge after the fault falls.
- R6: A main-supply flag at 0 sets the fault output two edges later and forces every gate to 0. When the flag returns to 1, the fault falls two edges later, with no clearance wait.
- R7: After reset, and after every main-supply undervoltage, each phase's high gate stays 0 until that phase's low command has been sampled at 1 with the supply flag at 1.
- R8: A bootstrap flag at 0 forces only that phase's high gate to 0. Low gates, other phases and the fault output are untouched. The high gate returns when the flag returns to 1.
- R9: An enable input at 0 forces every gate to 0 and leaves the fault output unchanged. Setting the enable back to 1 restores the gates if no fault is present.
- R10: The PFC gate follows the PFC command with a latency of two edges whenever there is no fault and the enable is 1.
- R11: While reset is asserted, and right after it is released, all gate outputs and the fault output are 0, and every high side is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | NUM_PH | High-side commands, bit p is phase p |
| pwm_lo | input | NUM_PH | Low-side commands, bit p is phase p |
| pfc_pwm | input | 1 | PFC switch command |
| oc_inv | input | 1 | Inverter over-current flag, 1 = over-current |
| oc_pfc | input | 1 | PFC over-current flag, 1 = over-current |
| sup_ok | input | 1 | Main supply good, 0 = undervoltage |
| boot_ok | input | NUM_PH | Bootstrap supply good per phase, 0 = undervoltage |
| drv_en | input | 1 | Driver enable, 1 = drivers allowed |
| gate_hs | output | NUM_PH | High-side gate enables |
| gate_ls | output | NUM_PH | Low-side gate enables |
| gate_pfc | output | 1 | PFC gate enable |
| fault | output | 1 | Registered fault level, 1 = fault active |

## Verification
Some rules are checked by assertions on every cycle. A fault or a low enable must clear all gates on the next edge. A phase with both commands at 1 or with a low bootstrap flag must lose its drive on the next edge. An accepted trip or a supply undervoltage must be followed by a fault. A disarmed phase must not drive its high side. Other behaviour can only be shown by the bench's scenarios, because it depends on exact counts over long windows. These are the edge at which a trip is accepted, the PROP_CYC delay, the full CLEAR_CYC wait after the flags drop, and the fact that a glitch shorter than the blanking window leaves no trace. The same holds for re-arming after reset and after supply recovery.

// File: rtl/gg_pkg.sv
package gg_pkg;

  localparam int N_TRIP = 2;  // index 0: inverter, index 1: PFC

  typedef enum logic {
    FILT_WATCH = 1'b0,
    FILT_DELAY = 1'b1
  } filt_st_t;

  typedef enum logic [1:0] {
    SUP_RUN   = 2'd0,
    SUP_HOLD  = 2'd1,
    SUP_DRAIN = 2'd2
  } sup_st_t;

endpackage

// File: rtl/gg_trip_filter.sv
module gg_trip_filter
  import gg_pkg::*;
#(
  parameter int BLANK_CYC = 35,
  parameter int PROP_CYC  = 60
) (
  input  logic clk,
  input  logic rstn,
  input  logic flag,
  output logic fire
);

  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int PW = $clog2(PROP_CYC + 1);
  localparam logic [BW-1:0] B_LAST = BW'(BLANK_CYC - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PROP_CYC - 1);

  filt_st_t       st_q, st_d;
  logic [BW-1:0]  blank_q, blank_d;
  logic [PW-1:0]  prop_q, prop_d;
  logic           fire_q, fire_d;

  always_comb begin
    st_d    = st_q;
    blank_d = blank_q;
    prop_d  = prop_q;
    fire_d  = 1'b0;
    unique case (st_q)
      FILT_WATCH: begin
        if (!flag) begin
          blank_d = '0;
        end else if (blank_q == B_LAST) begin
          blank_d = '0;
          prop_d  = '0;
          st_d    = FILT_DELAY;
        end else begin
          blank_d = blank_q + 1'b1;
        end
      end
      FILT_DELAY: begin
        if (prop_q == P_LAST) begin
          fire_d = 1'b1;
          st_d   = FILT_WATCH;
        end else begin
          prop_d = prop_q + 1'b1;
        end
      end
      default: st_d = FILT_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      st_q    <= FILT_WATCH;
      blank_q <= '0;
      prop_q  <= '0;
      fire_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      blank_q <= blank_d;
      prop_q  <= prop_d;
      fire_q  <= fire_d;
    end
  end

  assign fire = fire_q;

  AST_NO_EARLY_FIRE: assert property (@(posedge clk) disable iff (!rstn)
    (st_q == FILT_WATCH && blank_q == '0) |=> !fire_q); // R3

endmodule

// File: rtl/gg_fault_ctrl.sv
module gg_fault_ctrl
  import gg_pkg::*;
#(
  parameter int CLEAR_CYC = 165000
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic [N_TRIP-1:0] fire,
  input  logic [N_TRIP-1:0] trip_raw,
  input  logic              sup_ok,
  output logic              fault
);

  localparam int CW = $clog2(CLEAR_CYC + 1);
  localparam logic [CW-1:0] C_LAST = CW'(CLEAR_CYC - 1);

  sup_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d;
  logic          any_fire, any_trip;

  assign any_fire = |fire;
  assign any_trip = |trip_raw;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SUP_RUN: begin
        if (any_fire) st_d = SUP_HOLD;
      end
      SUP_HOLD: begin
        if (!any_trip) begin
          st_d  = SUP_DRAIN;
          cnt_d = '0;
        end
      end
      SUP_DRAIN: begin
        if (any_trip) begin
          st_d = SUP_HOLD;
        end else if (cnt_q == C_LAST) begin
          st_d = SUP_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SUP_RUN;
    endcase
    fault_d = (st_d != SUP_RUN) || !sup_ok;
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      st_q    <= SUP_RUN;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;

  AST_TRIP_SETS_FAULT: assert property (@(posedge clk) disable iff (!rstn)
    any_fire |=> fault_q); // R4
  AST_UV_SETS_FAULT: assert property (@(posedge clk) disable iff (!rstn)
    !sup_ok |=> fault_q); // R6
  AST_HOLD_WHILE_TRIP: assert property (@(posedge clk) disable iff (!rstn)
    (st_q != SUP_RUN && any_trip) |=> fault_q); // R5

endmodule

// File: rtl/gg_phase_gate.sv
module gg_phase_gate (
  input  logic clk,
  input  logic rstn,
  input  logic hi,
  input  logic lo,
  input  logic boot_ok,
  input  logic sup_ok,
  input  logic run,
  output logic gate_hs,
  output logic gate_ls
);

  logic armed_q, armed_d;
  logic hs_q, hs_d;
  logic ls_q, ls_d;
  logic hs_only, ls_only;

  assign hs_only = hi && !lo;
  assign ls_only = lo && !hi;

  always_comb begin
    if (!sup_ok)  armed_d = 1'b0;
    else if (lo)  armed_d = 1'b1;
    else          armed_d = armed_q;
    hs_d = hs_only && armed_q && boot_ok && run;
    ls_d = ls_only && run;
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      armed_q <= 1'b0;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      hs_q    <= hs_d;
      ls_q    <= ls_d;
    end
  end

  assign gate_hs = hs_q;
  assign gate_ls = ls_q;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstn)
    (hi && lo) |=> (!hs_q && !ls_q)); // R1
  AST_DISARMED_HS_OFF: assert property (@(posedge clk) disable iff (!rstn)
    !armed_q |=> !hs_q); // R7
  AST_ARM_NEEDS_LS: assert property (@(posedge clk) disable iff (!rstn)
    (!armed_q && !lo) |=> !armed_q); // R7
  AST_BOOT_CUTS_HS: assert property (@(posedge clk) disable iff (!rstn)
    !boot_ok |=> !hs_q); // R8

endmodule

// File: rtl/gate_guard.sv
module gate_guard
  import gg_pkg::*;
#(
  parameter int NUM_PH    = 3,
  parameter int BLANK_CYC = 35,
  parameter int PROP_CYC  = 60,
  parameter int CLEAR_CYC = 165000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] pwm_hi,
  input  logic [NUM_PH-1:0] pwm_lo,
  input  logic              pfc_pwm,
  input  logic              oc_inv,
  input  logic              oc_pfc,
  input  logic              sup_ok,
  input  logic [NUM_PH-1:0] boot_ok,
  input  logic              drv_en,
  output logic [NUM_PH-1:0] gate_hs,
  output logic [NUM_PH-1:0] gate_ls,
  output logic              gate_pfc,
  output logic              fault
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rstn_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rstn_i = rst_sync_q[1];

  // input register stage
  logic [NUM_PH-1:0] hi_q, lo_q, boot_q;
  logic              pfc_q, sup_q, en_q;

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      hi_q   <= '0;
      lo_q   <= '0;
      boot_q <= '0;
      pfc_q  <= 1'b0;
      sup_q  <= 1'b1;
      en_q   <= 1'b0;
    end else begin
      hi_q   <= pwm_hi;
      lo_q   <= pwm_lo;
      boot_q <= boot_ok;
      pfc_q  <= pfc_pwm;
      sup_q  <= sup_ok;
      en_q   <= drv_en;
    end
  end

  // trip filters, one per over-current source
  logic [N_TRIP-1:0] trip_raw, fire_v;
  assign trip_raw = {oc_pfc, oc_inv};

  for (genvar t = 0; t < N_TRIP; t++) begin : g_trip
    gg_trip_filter #(
      .BLANK_CYC(BLANK_CYC),
      .PROP_CYC (PROP_CYC)
    ) u_filt (
      .clk (clk),
      .rstn(rstn_i),
      .flag(trip_raw[t]),
      .fire(fire_v[t])
    );
  end

  logic fault_q;

  gg_fault_ctrl #(
    .CLEAR_CYC(CLEAR_CYC)
  ) u_fault (
    .clk     (clk),
    .rstn    (rstn_i),
    .fire    (fire_v),
    .trip_raw(trip_raw),
    .sup_ok  (sup_q),
    .fault   (fault_q)
  );

  logic run;
  assign run = en_q && !fault_q;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    gg_phase_gate u_ph (
      .clk    (clk),
      .rstn   (rstn_i),
      .hi     (hi_q[p]),
      .lo     (lo_q[p]),
      .boot_ok(boot_q[p]),
      .sup_ok (sup_q),
      .run    (run),
      .gate_hs(gate_hs[p]),
      .gate_ls(gate_ls[p])
    );
  end

  logic pfc_gate_q, pfc_gate_d;
  assign pfc_gate_d = pfc_q && run;

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) pfc_gate_q <= 1'b0;
    else         pfc_gate_q <= pfc_gate_d;
  end

  assign gate_pfc = pfc_gate_q;
  assign fault    = fault_q;

  AST_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (!rstn_i)
    fault_q |=> (gate_hs == '0 && gate_ls == '0 && !gate_pfc)); // R4
  AST_DISABLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rstn_i)
    !en_q |=> (gate_hs == '0 && gate_ls == '0 && !gate_pfc)); // R9

endmodule

// File: tb/test_gate_guard.sv
module test_gate_guard;

  localparam int NP = 3;
  localparam int BL = 4;
  localparam int PR = 3;
  localparam int CL = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pwm_hi, pwm_lo, boot_ok;
  logic          pfc_pwm, oc_inv, oc_pfc, sup_ok, drv_en;
  logic [NP-1:0] gate_hs, gate_ls;
  logic          gate_pfc, fault;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gate_guard #(
    .NUM_PH(NP), .BLANK_CYC(BL), .PROP_CYC(PR), .CLEAR_CYC(CL)
  ) i_gate_guard (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .pfc_pwm(pfc_pwm), .oc_inv(oc_inv), .oc_pfc(oc_pfc), .sup_ok(sup_ok),
    .boot_ok(boot_ok), .drv_en(drv_en), .gate_hs(gate_hs), .gate_ls(gate_ls),
    .gate_pfc(gate_pfc), .fault(fault)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] all_gates();
    return {1'b0, gate_pfc, gate_hs, gate_ls};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; pwm_hi = '0; pwm_lo = '0; pfc_pwm = 1'b0;
    oc_inv = 1'b0; oc_pfc = 1'b0; sup_ok = 1'b1; boot_ok = '1; drv_en = 1'b1;
    step(3);
    chk("R11", "gates in reset", all_gates(), 8'h00);
    rst_n = 1'b1;
    step(4);
    chk("R11", "gates after reset", all_gates(), 8'h00);
    chk("R11", "fault after reset", {7'd0, fault}, 8'h00);
  endtask

  task automatic t_arm();
    pwm_hi = 3'b001; step(2);
    chk("R7", "high side before any low cmd", {5'd0, gate_hs}, 8'h00);
    pwm_hi = '0; pwm_lo = 3'b111; step(2);
    chk("R2", "low gates", {5'd0, gate_ls}, 8'h07);
    pwm_lo = '0; pwm_hi = 3'b101; step(2);
    chk("R2", "high gates", {5'd0, gate_hs}, 8'h05);
    chk("R2", "low gates idle", {5'd0, gate_ls}, 8'h00);
  endtask

  task automatic t_interlock();
    pwm_hi = 3'b111; pwm_lo = 3'b010; step(2);
    chk("R1", "high gates with phase1 both", {5'd0, gate_hs}, 8'h05);
    chk("R1", "low gates with phase1 both", {5'd0, gate_ls}, 8'h00);
    pwm_lo = '0; step(2);
    chk("R1", "high gates after release", {5'd0, gate_hs}, 8'h07);
  endtask

  task automatic t_pfc();
    pfc_pwm = 1'b1; step(2);
    chk("R10", "pfc on", {7'd0, gate_pfc}, 8'h01);
    pfc_pwm = 1'b0; step(2);
    chk("R10", "pfc off", {7'd0, gate_pfc}, 8'h00);
    pfc_pwm = 1'b1; step(2);
  endtask

  task automatic t_boot();
    boot_ok = 3'b110; step(2);
    chk("R8", "high gates with phase0 boot low", {5'd0, gate_hs}, 8'h06);
    chk("R8", "fault with boot low", {7'd0, fault}, 8'h00);
    boot_ok = 3'b111; step(2);
    chk("R8", "high gates after boot back", {5'd0, gate_hs}, 8'h07);
  endtask

  task automatic t_enable();
    drv_en = 1'b0; step(2);
    chk("R9", "gates disabled", all_gates(), 8'h00);
    chk("R9", "fault while disabled", {7'd0, fault}, 8'h00);
    drv_en = 1'b1; step(2);
    chk("R9", "gates re-enabled", all_gates(), 8'h78);
  endtask

  task automatic t_glitch();
    oc_inv = 1'b1; step(BL - 1); oc_inv = 1'b0;
    oc_pfc = 1'b1; step(BL - 1); oc_pfc = 1'b0;
    step(BL + PR + 4);
    chk("R3", "fault after short glitches", {7'd0, fault}, 8'h00);
    chk("R3", "gates after short glitches", all_gates(), 8'h78);
  endtask

  task automatic t_trip(input bit use_pfc);
    if (use_pfc) oc_pfc = 1'b1; else oc_inv = 1'b1;
    step(BL + PR);
    chk("R3", "fault one edge before due", {7'd0, fault}, 8'h00);
    step(1);
    chk("R4", use_pfc ? "fault from pfc trip" : "fault from inv trip",
        {7'd0, fault}, 8'h01);
    step(1);
    chk("R4", "all gates off on trip", all_gates(), 8'h00);
    step(30);
    chk("R5", "fault held while flag high", {7'd0, fault}, 8'h01);
    oc_pfc = 1'b0; oc_inv = 1'b0;
    step(CL);
    chk("R5", "fault held during clearance", {7'd0, fault}, 8'h01);
    step(1);
    chk("R5", "fault cleared after wait", {7'd0, fault}, 8'h00);
    step(1);
    chk("R5", "gates resume", all_gates(), 8'h78);
  endtask

  task automatic t_restart_clear();
    oc_inv = 1'b1; step(BL + PR + 2);
    oc_inv = 1'b0; step(CL / 2);
    oc_inv = 1'b1; step(1); oc_inv = 1'b0;
    step(CL);
    chk("R5", "wait restarted by flag", {7'd0, fault}, 8'h01);
    step(1);
    chk("R5", "fault cleared after restart", {7'd0, fault}, 8'h00);
    step(1);
  endtask

  task automatic t_uv();
    sup_ok = 1'b0; step(3);
    chk("R6", "fault on supply uv", {7'd0, fault}, 8'h01);
    chk("R6", "gates off on supply uv", all_gates(), 8'h00);
    sup_ok = 1'b1; step(2);
    chk("R6", "fault released on supply good", {7'd0, fault}, 8'h00);
    step(1);
    chk("R7", "high side disarmed after uv", {5'd0, gate_hs}, 8'h00);
    chk("R6", "pfc back after uv", {7'd0, gate_pfc}, 8'h01);
    pwm_hi = '0; pwm_lo = 3'b111; step(2);
    chk("R7", "low gates re-arming", {5'd0, gate_ls}, 8'h07);
    pwm_lo = '0; pwm_hi = 3'b111; step(2);
    chk("R7", "high gates after re-arm", {5'd0, gate_hs}, 8'h07);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_arm();
    t_interlock();
    t_pfc();
    t_boot();
    t_enable();
    t_glitch();
    t_trip(1'b0);
    t_trip(1'b1);
    t_restart_clear();
    t_uv();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule